// File: doc/BRIEF.md
# UART receive idle timeout detector

This block sits beside a UART receiver and measures how long the receive line stays quiet after a character has arrived. Quiet time is counted in whole character times, where one character time is the number of bit periods a complete frame of the current format would occupy. When a programmed number of such idle character times elapses before the next data character, the block emits a one-cycle timeout pulse. A receive buffer manager uses that pulse to close a partly filled buffer and hand it to software, so the idle gap acts as a frame delimiter.

The block receives a bit-rate strobe, the sampled line level and a pulse for each completed character from the receiver. The frame format is given by data length, parity enable and stop-bit selection, and the idle limit is a 16-bit value. A sticky pending flag records each timeout. The flag is gated by a mask bit to form an interrupt request and is cleared by a write-one-to-clear pulse.

Top module: `uart_idle_timeout`

## Requirements
- R1: One character time in bit strobes is 1 + D + P + S. D is `data_bits_i` limited to the range 5 to 9, with values below 5 treated as 5 and above 9 as 9. P is 1 when `parity_en_i` is high. S is 2 when `two_stop_i` is high and 1 otherwise. For example, 8 data bits, no parity and one stop bit give 10.
- R2: After reset, `timeout_o` and `irq_o` are low, and no timeout occurs before the first `char_rx_i` pulse, whatever the line and strobes do.
- R3: After a `char_rx_i` pulse with limit L, `timeout_o` is high for exactly one cycle. That cycle follows the clock edge that samples the strobe completing the L-th idle character time.
- R4: An idle character time completes only after a full character time of consecutive strobes that all sample the line high. A strobe that samples the line low discards the partial character but keeps the idle characters already completed.
- R5: A `char_rx_i` pulse restarts both the partial bit count and the idle character count. It takes priority over a strobe in the same cycle.
- R6: While `idle_limit_i` is zero, no timeout is produced. A zero limit at character reception disables counting until the next character.
- R7: After a timeout, no further timeout occurs until another `char_rx_i` pulse.
- R8: A timeout sets a pending flag that stays set until an `irq_clr_i` pulse. A timeout in the same cycle as a clear leaves the flag set.
- R9: `irq_o` is the pending flag ANDed with `irq_mask_i`. The mask does not change the pending flag.
- R10: Idle counting advances only in cycles where `bit_tick_i` is high. Cycles without a strobe leave the count unchanged.
- R11: The idle limit is captured at the `char_rx_i` pulse. A later change to another nonzero value does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per bit period |
| rxd_i | input | 1 | Receive line level, 1 = mark |
| char_rx_i | input | 1 | Pulse when a data character has been received |
| data_bits_i | input | 4 | Data bits per character (5 to 9) |
| parity_en_i | input | 1 | Frame includes a parity bit |
| two_stop_i | input | 1 | Frame has two stop bits |
| idle_limit_i | input | 16 | Idle characters before timeout, 0 disables |
| irq_mask_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the pending flag |
| timeout_o | output | 1 | One-cycle idle timeout pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
An internal fault shows up as a timeout that arrives early, arrives late or never arrives. A wrong bit counter moves the pulse by a multiple of the strobe spacing within the first idle character. A wrong character counter moves it by whole character times. A fault in the arming state appears either as a second pulse on continued idle or as a pulse before any character has been received. The bench counts strobes between `char_rx_i` and the pulse for several frame formats and limits, and it compares `timeout_o` and `irq_o` against a reference model in every cycle. A divergence is therefore reported in the cycle it first appears at the ports.

// File: rtl/idle_to_pkg.sv
package idle_to_pkg;
  localparam int unsigned DB_W   = 4;
  localparam int unsigned LEN_W  = DB_W + 1;
  localparam int unsigned DB_MIN = 5;
  localparam int unsigned DB_MAX = 9;

  // frame length minus one, i.e. index of the last bit in a character
  function automatic logic [LEN_W-1:0] last_bit_idx(input logic [DB_W-1:0] db,
                                                    input logic par,
                                                    input logic two_stop);
    logic [LEN_W-1:0] d;
    if (db < DB_W'(DB_MIN))      d = LEN_W'(DB_MIN);
    else if (db > DB_W'(DB_MAX)) d = LEN_W'(DB_MAX);
    else                         d = LEN_W'(db);
    return d + LEN_W'(par) + (two_stop ? LEN_W'(2) : LEN_W'(1));
  endfunction
endpackage

// File: rtl/idle_frame_len.sv
module idle_frame_len
  import idle_to_pkg::*;
(
  input  logic [DB_W-1:0]  data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  output logic [LEN_W-1:0] last_idx_o
);
  always_comb last_idx_o = last_bit_idx(data_bits_i, parity_en_i, two_stop_i);
endmodule

// File: rtl/idle_bit_timer.sv
module idle_bit_timer #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [LEN_W-1:0] last_idx_i,
  output logic             char_done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             at_end;

  // >= guards against a format change shrinking the frame mid count
  assign at_end      = (cnt_q >= last_idx_i);
  assign char_done_o = run_i & tick_i & line_i & at_end & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i) begin
      if (!line_i || at_end)    cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/idle_char_count.sv
module idle_char_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             step_i,
  output logic             armed_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] left_q;
  logic             armed_q;
  logic             last;

  assign last     = (left_q == CNT_W'(1));
  assign armed_o  = armed_q;
  assign expire_o = step_i & armed_q & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      left_q  <= limit_i;
      armed_q <= |limit_i;
    end else if (step_i && armed_q) begin
      left_q  <= left_q - 1'b1;
      if (last) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/idle_irq_status.sv
module idle_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set_i | (pend_q & ~clr_i);
  end

  assign irq_o = pend_q & mask_i;
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
  import idle_to_pkg::*;
#(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               rxd_i,
  input  logic               char_rx_i,
  input  logic [DB_W-1:0]    data_bits_i,
  input  logic               parity_en_i,
  input  logic               two_stop_i,
  input  logic [LIMIT_W-1:0] idle_limit_i,
  input  logic               irq_mask_i,
  input  logic               irq_clr_i,
  output logic               timeout_o,
  output logic               irq_o
);
  logic [LEN_W-1:0] last_idx;
  logic             armed, run, char_done, expire, timeout_q;

  assign run = armed & (|idle_limit_i);

  idle_frame_len u_len (
    .data_bits_i (data_bits_i),
    .parity_en_i (parity_en_i),
    .two_stop_i  (two_stop_i),
    .last_idx_o  (last_idx)
  );

  idle_bit_timer #(.LEN_W(LEN_W)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (char_rx_i),
    .run_i       (run),
    .tick_i      (bit_tick_i),
    .line_i      (rxd_i),
    .last_idx_i  (last_idx),
    .char_done_o (char_done)
  );

  idle_char_count #(.CNT_W(LIMIT_W)) u_chars (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (char_rx_i),
    .limit_i  (idle_limit_i),
    .step_i   (char_done),
    .armed_o  (armed),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_q <= 1'b0;
    else         timeout_q <= expire;
  end
  assign timeout_o = timeout_q;

  idle_irq_status u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (irq_clr_i),
    .mask_i (irq_mask_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/uart_idle_timeout_chk.sv
module uart_idle_timeout_chk
  import idle_to_pkg::*;
#(
  parameter int unsigned LIMIT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_tick_i,
  input logic               rxd_i,
  input logic               char_rx_i,
  input logic [DB_W-1:0]    data_bits_i,
  input logic               parity_en_i,
  input logic               two_stop_i,
  input logic [LIMIT_W-1:0] idle_limit_i,
  input logic               irq_mask_i,
  input logic               irq_clr_i,
  input logic               timeout_o,
  input logic               irq_o
);
  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  p_low_aborts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxd_i |=> !timeout_o);
  p_rx_restarts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_rx_i |=> !timeout_o);
  p_zero_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_limit_i == '0) |=> !timeout_o);
  p_set_on_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && irq_mask_i) |-> irq_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> (irq_o || !irq_mask_i));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i |=> (timeout_o || !irq_o));
  p_needs_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> !timeout_o);
endmodule

bind uart_idle_timeout uart_idle_timeout_chk #(.LIMIT_W(LIMIT_W)) u_chk (.*);

// File: tb/sim_uart_idle_timeout.sv
module sim_uart_idle_timeout;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 0, rxd = 1, rx = 0, clr = 0, par = 0, two = 0, mask = 0;
  logic [3:0]  db = 4'd8;
  logic [15:0] limit = 16'd0;
  logic        to_o, irq_o;

  int n_chk = 0, n_fail = 0;
  int m_armed = 0, m_bits = 0, m_left = 0, m_pend = 0, m_to = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_idle_timeout u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .rxd_i(rxd), .char_rx_i(rx),
    .data_bits_i(db), .parity_en_i(par), .two_stop_i(two), .idle_limit_i(limit),
    .irq_mask_i(mask), .irq_clr_i(clr), .timeout_o(to_o), .irq_o(irq_o)
  );

  function automatic int flen(input int d, input bit p, input bit t);
    int dd = (d < 5) ? 5 : (d > 9) ? 9 : d;
    return 1 + dd + int'(p) + (t ? 2 : 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference step from the requirements, one clock edge
  task automatic model(input bit t, input bit r, input bit x, input bit c);
    m_to = 0;
    if (x) begin
      m_armed = (limit != 0); m_bits = 0; m_left = limit;
    end else if (m_armed != 0 && limit != 0 && t) begin
      if (!r) m_bits = 0;
      else if (m_bits + 1 >= flen(db, par, two)) begin
        m_bits = 0; m_left--;
        if (m_left == 0) begin m_to = 1; m_armed = 0; end
      end else m_bits++;
    end
    m_pend = m_to | (m_pend & ~int'(c));
  endtask

  // called at a negedge: drive, pass one posedge, compare at next negedge
  task automatic apply(input bit t, input bit r, input bit x, input bit c);
    tick = t; rxd = r; rx = x; clr = c;
    @(negedge clk);
    model(t, r, x, c);
    chk("R3 timeout_o", int'(to_o), m_to);
    chk("R9 irq_o", int'(irq_o), m_pend & int'(mask));
    tick = 0; rx = 0; clr = 0; rxd = 1;
  endtask

  // strobes with line high until timeout; returns count or 0
  task automatic ticks_to_timeout(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      apply(1, 1, 0, 0);
      if (to_o) begin n = i; return; end
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    chk("R2 reset timeout_o", int'(to_o), 0);
    chk("R2 reset irq_o", int'(irq_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: no character yet
    limit = 1; mask = 1;
    for (int i = 0; i < 30; i++) apply(1, 1, 0, 0);

    // R1 / R3: strobe count per format and limit
    begin
      int fmt[4][3] = '{'{8,0,0}, '{5,0,0}, '{9,1,1}, '{3,1,0}};
      for (int f = 0; f < 4; f++) begin
        db = 4'(fmt[f][0]); par = fmt[f][1][0]; two = fmt[f][2][0];
        limit = 16'(f + 1);
        apply(0, 1, 1, 0);
        ticks_to_timeout(200, n);
        chk("R1 ticks to timeout", n, (f + 1) * flen(fmt[f][0], par, two));
        // R7: stays quiet after firing
        ticks_to_timeout(60, n);
        chk("R7 no second timeout", n, 0);
      end
    end
    apply(0, 1, 0, 1);

    // R4: low sample drops partial character only
    db = 8; par = 0; two = 0; limit = 2;
    apply(0, 1, 1, 0);
    for (int i = 0; i < 10; i++) apply(1, 1, 0, 0);
    for (int i = 0; i < 4; i++) apply(1, 1, 0, 0);
    apply(1, 0, 0, 0);
    ticks_to_timeout(100, n);
    chk("R4 after low sample", n, 10);

    // R5: restart, rx beats a same-cycle strobe
    limit = 1;
    apply(0, 1, 1, 0);
    for (int i = 0; i < 7; i++) apply(1, 1, 0, 0);
    apply(1, 1, 1, 0);
    ticks_to_timeout(100, n);
    chk("R5 restart on char", n, 10);

    // R6: zero limit
    limit = 0;
    apply(0, 1, 1, 0);
    ticks_to_timeout(100, n);
    chk("R6 zero at load", n, 0);
    limit = 1;
    apply(0, 1, 1, 0);
    for (int i = 0; i < 5; i++) apply(1, 1, 0, 0);
    limit = 0;
    for (int i = 0; i < 30; i++) apply(1, 1, 0, 0);
    chk("R6 zero mid count", int'(to_o), 0);
    limit = 1;
    ticks_to_timeout(100, n);
    chk("R6 resumes", n, 5);

    // R10: no strobe, no progress
    apply(0, 1, 1, 0);
    for (int i = 0; i < 4; i++) apply(1, 1, 0, 0);
    for (int i = 0; i < 50; i++) apply(0, 1, 0, 0);
    ticks_to_timeout(100, n);
    chk("R10 strobe gated", n, 6);

    // R11: limit captured at character
    limit = 2;
    apply(0, 1, 1, 0);
    limit = 5;
    ticks_to_timeout(200, n);
    chk("R11 captured limit", n, 20);

    // R8 / R9: sticky flag, mask, clear priority
    mask = 0; limit = 1;
    apply(0, 1, 0, 1);
    apply(0, 1, 1, 0);
    ticks_to_timeout(100, n);
    chk("R9 masked irq", int'(irq_o), 0);
    mask = 1;
    #1 chk("R9 unmask shows pending", int'(irq_o), 1);
    for (int i = 0; i < 5; i++) apply(0, 1, 0, 0);
    chk("R8 sticky", int'(irq_o), 1);
    apply(0, 1, 0, 1);
    chk("R8 cleared", int'(irq_o), 0);
    apply(0, 1, 1, 0);
    for (int i = 0; i < 9; i++) apply(1, 1, 0, 0);
    apply(1, 1, 0, 1);
    chk("R8 set beats clear", int'(irq_o), 1);
    apply(0, 1, 0, 1);

    // random mix against the reference model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 199) == 0) begin
        db = 4'($urandom_range(4, 10)); par = 1'($urandom); two = 1'($urandom);
      end
      if ($urandom_range(0, 99) == 0) limit = 16'($urandom_range(0, 3));
      mask = ($urandom_range(0, 7) != 0);
      apply($urandom_range(0, 2) != 0, $urandom_range(0, 39) != 0,
            $urandom_range(0, 59) == 0, $urandom_range(0, 49) == 0);
    end

    summary();
    $finish;
  end
endmodule